// File: doc/BRIEF.md
# Indirect Flash Read FIFO Engine

This block runs the data side of an indirect read from a serial flash. Software loads a transfer length and a flash start address, then writes a start bit into an eight-bit control register. The engine then accepts bytes from the flash-side shifter, which appears here as a simple valid/ready byte stream. It packs them into words and stores them in the read half of a local SRAM FIFO. A bus master drains that FIFO one word at a time. The master knows how much to drain from a word-granular fill level, and it keeps reading while that level is non-zero.

The control register has four bits with meaning. Start and cancel are action bits. Busy is read-only. Done is set by hardware and cleared when software writes a one to it. A length that is not a whole number of words ends with a zero-padded word. Cancel stops the transfer and empties the FIFO without reporting completion. When the read partition is full, the engine stops taking bytes from the flash side until the master drains a word.

Top module: `flash_rdq_engine`

## Requirements
- R1: After reset, `ctl_status` is 0, `fill_level` is 0 and `fl_ready` is 0.
- R2: A control write with bit 0 (start) set and bit 1 clear, made while idle with a non-zero length, sets busy (status bit 2) and clears done (status bit 5) from the next cycle. A start written while busy is ignored.
- R3: Bytes are packed little-endian: the first byte of each group of four goes to bits 7:0 of `drain_data`. `fill_level` goes up by one in the cycle after the fourth byte of a word is accepted.
- R4: If the length is not a multiple of four, the last word holds the remaining bytes in its low lanes, the unused lanes are zero, and that word counts as one level entry.
- R5: In the cycle after the last byte is accepted, busy reads 0 and done reads 1. While busy is 0, `fl_ready` is 0.
- R6: A control write with bit 5 set clears done. A control write with bit 5 clear leaves done unchanged.
- R7: `fill_level` never exceeds the read partition (half of `FIFO_WORDS`, 16 by default). While it equals that value, `fl_ready` is 0.
- R8: A control write with bit 1 (cancel) set clears busy, empties the FIFO and any partly packed word (so `fill_level` is 0 on the next cycle), and leaves done as it was. Cancel takes priority over a start bit in the same write. Cancel also flushes the FIFO when the engine is idle.
- R9: A `drain_rd` pulse while `fill_level` is non-zero puts the oldest word on `drain_data` in the next cycle and lowers the level by one. A pulse at level 0 has no effect on the level.
- R10: A start with a programmed length of 0 sets done on the next cycle and never sets busy.
- R11: From the cycle after an accepted start, `fl_addr` holds the start address that was programmed before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_wr | input | 1 | Write strobe for the byte-count register |
| len_wdata | input | LEN_W (16) | Byte count to transfer |
| addr_wr | input | 1 | Write strobe for the start-address register |
| addr_wdata | input | ADDR_W (32) | Flash start address |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data: bit 0 start, bit 1 cancel, bit 5 clear done |
| ctl_status | output | 8 | Status: bit 2 busy, bit 5 done, all other bits 0 |
| fl_addr | output | ADDR_W (32) | Start address latched at start, for the flash shifter |
| fl_valid | input | 1 | Flash byte valid |
| fl_data | input | 8 | Flash byte |
| fl_ready | output | 1 | Engine accepts a flash byte this cycle |
| drain_rd | input | 1 | Pop one word from the read FIFO |
| drain_data | output | 8*BYTES_PER_WORD (32) | Word popped on the previous cycle |
| fill_level | output | 16 | Number of words waiting in the read FIFO |

## Verification
Every result takes effect one clock edge after the event that causes it. Status bits change after the edge that accepts a control write or the last byte. The fill level changes after the edge that completes a word or accepts a pop. Popped data appears after the edge that samples `drain_rd`. The bench drives inputs on the falling edge and holds each one for exactly one rising edge. It then checks the results on the next falling edge, which is the first point where the registered outputs show the new value. Back-pressure is checked as a steady state over several cycles with a byte held valid, so the exact cycle of that check does not matter.

// File: rtl/frq_pkg.sv
package frq_pkg;
  // Control/status bit positions decoded by software
  localparam int CTL_W       = 8;
  localparam int BIT_START   = 0;
  localparam int BIT_CANCEL  = 1;
  localparam int BIT_BUSY    = 2;
  localparam int BIT_DONE    = 5;
  localparam int BYTE_W      = 8;
  localparam int LEVEL_W     = 16;
endpackage

// File: rtl/frq_fifo.sv
module frq_fifo #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && (count != '0) && !flush;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) pop_data <= '0;
    else if (do_pop) pop_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/frq_packer.sv
module frq_packer #(
  parameter int BPW     = 4,
  localparam int WORD_W = 8 * BPW,
  localparam int LANE_W = (BPW > 1) ? $clog2(BPW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              take,
  input  logic [7:0]        byte_in,
  input  logic              last,
  output logic              push,
  output logic [WORD_W-1:0] word_out
);
  logic [WORD_W-1:0] acc_q;
  logic [LANE_W-1:0] lane_q;

  // each lane takes the incoming byte when it is the current slot
  for (genvar g = 0; g < BPW; g++) begin : g_lane
    assign word_out[g*8 +: 8] = (take && lane_q == LANE_W'(g)) ? byte_in : acc_q[g*8 +: 8];
  end

  assign push = take && ((lane_q == LANE_W'(BPW - 1)) || last);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (push) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (take) begin
      acc_q  <= word_out;
      lane_q <= lane_q + LANE_W'(1);
    end
  end
endmodule

// File: rtl/frq_ctrl.sv
module frq_ctrl
  import frq_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              len_wr,
  input  logic [LEN_W-1:0]  len_wdata,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              byte_take,
  output logic              last_byte,
  output logic              cancel_now,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] xfer_addr
);
  logic [LEN_W-1:0]  len_q, remain_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start_now, clear_now;
  logic              unused_ctl;

  assign unused_ctl = ^{ctl_wdata[7:6], ctl_wdata[4:2]};
  assign cancel_now = ctl_wr && ctl_wdata[BIT_CANCEL];
  assign start_now  = ctl_wr && ctl_wdata[BIT_START] && !ctl_wdata[BIT_CANCEL] && !busy;
  assign clear_now  = ctl_wr && ctl_wdata[BIT_DONE];
  assign last_byte  = byte_take && (remain_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      addr_q <= '0;
    end else begin
      if (len_wr)  len_q  <= len_wdata;
      if (addr_wr) addr_q <= addr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      remain_q  <= '0;
      xfer_addr <= '0;
    end else begin
      if (cancel_now) begin
        busy <= 1'b0;
      end else if (start_now) begin
        busy      <= (len_q != '0);
        remain_q  <= len_q;
        xfer_addr <= addr_q;
      end else if (byte_take) begin
        remain_q <= remain_q - LEN_W'(1);
        if (last_byte) busy <= 1'b0;
      end

      if (start_now)                     done <= (len_q == '0);
      else if (last_byte && !cancel_now) done <= 1'b1;
      else if (clear_now)                done <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_rdq_engine.sv
module flash_rdq_engine
  import frq_pkg::*;
#(
  parameter int FIFO_WORDS     = 32,
  parameter int BYTES_PER_WORD = 4,
  parameter int LEN_W          = 16,
  parameter int ADDR_W         = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        len_wr,
  input  logic [LEN_W-1:0]            len_wdata,
  input  logic                        addr_wr,
  input  logic [ADDR_W-1:0]           addr_wdata,
  input  logic                        ctl_wr,
  input  logic [7:0]                  ctl_wdata,
  output logic [7:0]                  ctl_status,
  output logic [ADDR_W-1:0]           fl_addr,
  input  logic                        fl_valid,
  input  logic [7:0]                  fl_data,
  output logic                        fl_ready,
  input  logic                        drain_rd,
  output logic [8*BYTES_PER_WORD-1:0] drain_data,
  output logic [15:0]                 fill_level
);
  localparam int RD_WORDS = FIFO_WORDS / 2;
  localparam int WORD_W   = 8 * BYTES_PER_WORD;
  localparam int CNT_W    = $clog2(RD_WORDS + 1);

  logic              busy, done, cancel_now, last_byte, byte_take;
  logic              push, fifo_full;
  logic [WORD_W-1:0] push_word;
  logic [CNT_W-1:0]  count;

  assign fl_ready  = busy && !fifo_full && !cancel_now;
  assign byte_take = fl_valid && fl_ready;

  frq_ctrl #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .len_wr(len_wr), .len_wdata(len_wdata),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .byte_take(byte_take), .last_byte(last_byte), .cancel_now(cancel_now),
    .busy(busy), .done(done), .xfer_addr(fl_addr)
  );

  frq_packer #(.BPW(BYTES_PER_WORD)) pack_i (
    .clk(clk), .rst(rst), .flush(cancel_now),
    .take(byte_take), .byte_in(fl_data), .last(last_byte),
    .push(push), .word_out(push_word)
  );

  frq_fifo #(.DEPTH(RD_WORDS), .WIDTH(WORD_W)) fifo_i (
    .clk(clk), .rst(rst), .flush(cancel_now),
    .push(push), .push_data(push_word),
    .pop(drain_rd), .pop_data(drain_data),
    .count(count), .full(fifo_full)
  );

  always_comb begin
    ctl_status           = '0;
    ctl_status[BIT_BUSY] = busy;
    ctl_status[BIT_DONE] = done;
  end

  assign fill_level = LEVEL_W'(count);
endmodule

// File: rtl/flash_rdq_engine_chk.sv
module flash_rdq_engine_chk #(
  parameter int RD_WORDS = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        ctl_wr,
  input logic [7:0]  ctl_wdata,
  input logic [7:0]  ctl_status,
  input logic        fl_valid,
  input logic        fl_ready,
  input logic        drain_rd,
  input logic [15:0] fill_level
);
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    fill_level <= 16'(RD_WORDS));

  assert_full_stalls_R7: assert property (@(posedge clk) disable iff (rst)
    (fill_level == 16'(RD_WORDS)) |-> !fl_ready);

  assert_idle_stalls_R5: assert property (@(posedge clk) disable iff (rst)
    !ctl_status[2] |-> !fl_ready);

  assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(ctl_status[2] && ctl_status[5]));

  assert_cancel_flush_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[1]) |=> (!ctl_status[2] && fill_level == 16'd0));

  assert_cancel_keeps_done_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata[1] && !ctl_wdata[5] && ctl_status[5]) |=> ctl_status[5]);

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (drain_rd && fill_level == 16'd0 && !(fl_valid && fl_ready)) |=> fill_level == 16'd0);
endmodule

bind flash_rdq_engine flash_rdq_engine_chk #(.RD_WORDS(RD_WORDS)) chk_i (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_status(ctl_status), .fl_valid(fl_valid), .fl_ready(fl_ready),
  .drain_rd(drain_rd), .fill_level(fill_level)
);

// File: tb/flash_rdq_engine_tb_top.sv
module flash_rdq_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        len_wr = 1'b0, addr_wr = 1'b0, ctl_wr = 1'b0;
  logic [15:0] len_wdata = '0;
  logic [31:0] addr_wdata = '0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_status;
  logic [31:0] fl_addr;
  logic        fl_valid = 1'b0;
  logic [7:0]  fl_data = '0;
  logic        fl_ready;
  logic        drain_rd = 1'b0;
  logic [31:0] drain_data;
  logic [15:0] fill_level;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_rdq_engine dut_i (
    .clk(clk), .rst(rst),
    .len_wr(len_wr), .len_wdata(len_wdata),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_status(ctl_status),
    .fl_addr(fl_addr), .fl_valid(fl_valid), .fl_data(fl_data), .fl_ready(fl_ready),
    .drain_rd(drain_rd), .drain_data(drain_data), .fill_level(fill_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic set_len(input logic [15:0] n);
    len_wr = 1'b1; len_wdata = n;
    @(negedge clk); len_wr = 1'b0;
  endtask

  task automatic set_addr(input logic [31:0] a);
    addr_wr = 1'b1; addr_wdata = a;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    fl_valid = 1'b1; fl_data = b;
    while (!fl_ready) @(negedge clk);
    @(negedge clk); fl_valid = 1'b0;
  endtask

  task automatic pop_word();
    drain_rd = 1'b1;
    @(negedge clk); drain_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(ctl_status), 32'h0);
    chk("R1 level", 32'(fill_level), 32'h0);
    chk("R1 ready", 32'(fl_ready), 32'h0);
  endtask

  task automatic t_full_words();
    set_len(16'd8);
    set_addr(32'h0000_1000);
    wr_ctl(8'h01);
    chk("R2 busy after start", 32'(ctl_status), 32'h04);
    chk("R11 fl_addr", fl_addr, 32'h0000_1000);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    chk("R3 no level before 4th byte", 32'(fill_level), 32'd0);
    send_byte(8'h44);
    chk("R3 level after word", 32'(fill_level), 32'd1);
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h77); send_byte(8'h88);
    chk("R5 done after last byte", 32'(ctl_status), 32'h20);
    chk("R5 ready low when idle", 32'(fl_ready), 32'h0);
    chk("R3 level two words", 32'(fill_level), 32'd2);
    pop_word();
    chk("R3 R9 first word little-endian", drain_data, 32'h4433_2211);
    chk("R9 level after pop", 32'(fill_level), 32'd1);
    pop_word();
    chk("R9 second word", drain_data, 32'h8877_6655);
    pop_word();
    chk("R9 pop at empty", 32'(fill_level), 32'd0);
    wr_ctl(8'h00);
    chk("R6 done kept on zero write", 32'(ctl_status), 32'h20);
    wr_ctl(8'h20);
    chk("R6 done cleared by W1C", 32'(ctl_status), 32'h00);
  endtask

  task automatic t_partial();
    set_len(16'd6);
    wr_ctl(8'h20);
    wr_ctl(8'h01);
    send_byte(8'ha1); send_byte(8'ha2);
    wr_ctl(8'h01);
    set_len(16'd20);
    chk("R2 restart while busy ignored", 32'(ctl_status), 32'h04);
    send_byte(8'ha3); send_byte(8'ha4); send_byte(8'ha5); send_byte(8'ha6);
    chk("R2 original length kept", 32'(ctl_status), 32'h20);
    chk("R4 partial counts one entry", 32'(fill_level), 32'd2);
    pop_word();
    chk("R4 first word", drain_data, 32'ha4a3_a2a1);
    pop_word();
    chk("R4 zero padded tail", drain_data, 32'h0000_a6a5);
  endtask

  task automatic t_backpressure();
    set_len(16'd68);
    wr_ctl(8'h01);
    chk("R2 start clears done", 32'(ctl_status), 32'h04);
    for (int i = 0; i < 64; i++) send_byte(8'(i));
    chk("R7 level at partition", 32'(fill_level), 32'd16);
    fl_valid = 1'b1; fl_data = 8'hee;
    for (int k = 0; k < 3; k++) begin
      chk("R7 ready low when full", 32'(fl_ready), 32'h0);
      @(negedge clk);
    end
    chk("R7 level held", 32'(fill_level), 32'd16);
    fl_valid = 1'b0;
    pop_word();
    chk("R7 oldest word", drain_data, 32'h0302_0100);
    chk("R7 ready back after drain", 32'(fl_ready), 32'h1);
    for (int i = 0; i < 4; i++) send_byte(8'h40 + 8'(i));
    chk("R5 done after stall", 32'(ctl_status), 32'h20);
    chk("R7 level full again", 32'(fill_level), 32'd16);
    wr_ctl(8'h02);
    chk("R8 idle cancel flushes", 32'(fill_level), 32'd0);
    chk("R8 cancel keeps done", 32'(ctl_status), 32'h20);
  endtask

  task automatic t_cancel();
    set_len(16'd10);
    wr_ctl(8'h01);
    for (int i = 0; i < 5; i++) send_byte(8'hc0 + 8'(i));
    chk("R8 level before cancel", 32'(fill_level), 32'd1);
    wr_ctl(8'h03);
    chk("R8 busy cleared no done", 32'(ctl_status), 32'h00);
    chk("R8 level flushed", 32'(fill_level), 32'd0);
    chk("R8 ready low", 32'(fl_ready), 32'h0);
    set_len(16'd4);
    wr_ctl(8'h01);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
    pop_word();
    chk("R8 packer flushed", drain_data, 32'h0403_0201);
  endtask

  task automatic t_zero_len();
    set_len(16'd0);
    wr_ctl(8'h20);
    wr_ctl(8'h01);
    chk("R10 zero length done", 32'(ctl_status), 32'h20);
    chk("R10 ready low", 32'(fl_ready), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_words();
    t_partial();
    t_backpressure();
    t_cancel();
    t_zero_len();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule